// File: doc/BRIEF.md
# Serial Interrupt Status Aggregator

This block gathers the interrupt sources of a two-channel serial unit into one 8-bit status word and one interrupt request. Each channel supplies receiver-ready and transmitter-ready levels and a break-change strobe. A counter/timer supplies a ready strobe. Three general-purpose input pins are watched for transitions, and each transition is latched into a change capture register.

A simple register bus reads the status word and the change capture register. It also reads and writes an interrupt mask and an auxiliary control register, whose low three bits let each pin's change flag reach the status word. The mask gates only the interrupt request, so software always reads the true status. Each sticky source is cleared by a clear pulse from its owning logic. The pin change flags are cleared by reading the capture register.

Top module: `sio_irq_agg`

## Requirements
- R1: Status bits, from bit 7 down: 7 pin change, 6 break change B, 5 receiver ready B, 4 transmitter ready B, 3 counter/timer ready, 2 break change A, 1 receiver ready A, 0 transmitter ready A. Bits 5, 4, 1 and 0 follow their level inputs with no delay.
- R2: `irq_o` is registered. It goes high one clock after any status bit and its mask bit at the same position are both 1, and it goes low one clock after no such pair remains.
- R3: A status bit whose mask bit is 0 has no effect on `irq_o`. The mask resets to 0, so `irq_o` is low after reset.
- R4: A read of address 0 returns the unmasked status, whatever the mask holds.
- R5: After reset, the status word, mask, auxiliary register and capture register all read 0.
- R6: A transition on `pin_i[n]` sets capture bit n (address 3) on the third rising clock edge after the change. A pin level that is present through reset sets no flag.
- R7: Status bit 7 is 1 when some capture bit n is set and auxiliary bit n (address 2, bits 2:0) is also set. A capture bit whose enable is 0 leaves bit 7 unaffected.
- R8: A read of address 3 returns the capture flags and clears them. A new change in the same cycle wins over the clear.
- R9: A break-change or counter/timer strobe sets its status bit, and the matching clear pulse clears it. When both arrive in the same cycle, the set wins.
- R10: Register map: 0 status (read only), 1 mask (read/write, 8 bits), 2 auxiliary (read/write bits 2:0, upper bits read 0), 3 capture (read only, bits 2:0). Writes to addresses 0 and 3 are ignored. `bus_rdata_o` is 0 when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |
| rx_rdy_a_i | input | 1 | Channel A receiver ready level |
| tx_rdy_a_i | input | 1 | Channel A transmitter ready level |
| brk_set_a_i | input | 1 | Channel A break change strobe |
| brk_clr_a_i | input | 1 | Channel A break change clear |
| rx_rdy_b_i | input | 1 | Channel B receiver ready level |
| tx_rdy_b_i | input | 1 | Channel B transmitter ready level |
| brk_set_b_i | input | 1 | Channel B break change strobe |
| brk_clr_b_i | input | 1 | Channel B break change clear |
| ctr_set_i | input | 1 | Counter/timer ready strobe |
| ctr_clr_i | input | 1 | Counter/timer ready clear |
| pin_i | input | 3 | Asynchronous input pins |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A sticky bit or capture flag left in the wrong state shows at once on a status or capture read. It shows on `irq_o` one clock later, once the matching mask bit is set. A bad arming state of the pin synchroniser shows as a capture flag after reset with a pin held high. A clear that beats a same-cycle set shows as a lost flag on the next read. The bench therefore reads the registers back after each stimulus. It samples `irq_o` at the exact edge count that R2 and R6 give.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned NPIN   = 3;
  localparam int unsigned NSTICK = 3;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_MASK   = 2'd1,
    REG_AUX    = 2'd2,
    REG_CHG    = 2'd3
  } reg_addr_e;

  localparam int unsigned B_TXA = 0;
  localparam int unsigned B_RXA = 1;
  localparam int unsigned B_BKA = 2;
  localparam int unsigned B_CTR = 3;
  localparam int unsigned B_TXB = 4;
  localparam int unsigned B_RXB = 5;
  localparam int unsigned B_BKB = 6;
  localparam int unsigned B_COS = 7;
endpackage

// File: rtl/sio_pin_change.sv
module sio_pin_change #(
  parameter int unsigned NPIN = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pin_i,
  input  logic            clr_i,
  output logic [NPIN-1:0] flag_o
);
  logic [NPIN-1:0] s1_q, s2_q, prev_q, det;
  logic [1:0]      fill_q;
  logic            armed;

  assign armed = (fill_q == 2'd3);

  // hold off detection until the sync chain carries real pin levels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else if (!armed) fill_q <= fill_q + 2'd1;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[i]   <= 1'b0;
        s2_q[i]   <= 1'b0;
        prev_q[i] <= 1'b0;
        flag_o[i] <= 1'b0;
      end else begin
        s1_q[i]   <= pin_i[i];
        s2_q[i]   <= s1_q[i];
        prev_q[i] <= s2_q[i];
        if (det[i])     flag_o[i] <= 1'b1;
        else if (clr_i) flag_o[i] <= 1'b0;
      end
    end
    assign det[i] = armed && (s2_q[i] != prev_q[i]);

    a_r6_change_sets : assert property (@(posedge clk_i) disable iff (!rst_ni)
      det[i] |=> flag_o[i]);
    a_r8_read_clears : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !det[i]) |=> !flag_o[i]);
  end
endmodule

// File: rtl/sio_sticky.sv
module sio_sticky #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end

    a_r9_set_wins : assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);
    a_r9_clear : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);
  end
endmodule

// File: rtl/sio_ctl_regs.sv
module sio_ctl_regs
  import sio_irq_pkg::*;
#(
  parameter int unsigned STAT_W = 8,
  parameter int unsigned NPIN   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] mask_o,
  output logic [NPIN-1:0]   en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      en_o   <= '0;
    end else if (wr_i) begin
      if (addr_i == REG_MASK) mask_o <= wdata_i;
      if (addr_i == REG_AUX)  en_o   <= wdata_i[NPIN-1:0];
    end
  end

  a_r10_mask_write : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_MASK) |=> (mask_o == $past(wdata_i)));
  a_r10_mask_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == REG_MASK) |=> $stable(mask_o));
endmodule

// File: rtl/sio_irq_agg.sv
module sio_irq_agg
  import sio_irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  bus_addr_i,
  input  logic        bus_wr_i,
  input  logic        bus_rd_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  input  logic        rx_rdy_a_i,
  input  logic        tx_rdy_a_i,
  input  logic        brk_set_a_i,
  input  logic        brk_clr_a_i,
  input  logic        rx_rdy_b_i,
  input  logic        tx_rdy_b_i,
  input  logic        brk_set_b_i,
  input  logic        brk_clr_b_i,
  input  logic        ctr_set_i,
  input  logic        ctr_clr_i,
  input  logic [2:0]  pin_i,
  output logic        irq_o
);
  logic [STAT_W-1:0] status, mask;
  logic [NPIN-1:0]   chg_flag, chg_en;
  logic [NSTICK-1:0] stk_set, stk_clr, stk_q;
  logic              chg_rd;

  assign chg_rd  = bus_rd_i && (bus_addr_i == REG_CHG);
  // sticky order: 0 break A, 1 counter/timer, 2 break B
  assign stk_set = {brk_set_b_i, ctr_set_i, brk_set_a_i};
  assign stk_clr = {brk_clr_b_i, ctr_clr_i, brk_clr_a_i};

  sio_pin_change #(.NPIN(NPIN)) u_pins (
    .clk_i, .rst_ni, .pin_i, .clr_i(chg_rd), .flag_o(chg_flag)
  );

  sio_sticky #(.N(NSTICK)) u_stk (
    .clk_i, .rst_ni, .set_i(stk_set), .clr_i(stk_clr), .q_o(stk_q)
  );

  sio_ctl_regs #(.STAT_W(STAT_W), .NPIN(NPIN)) u_regs (
    .clk_i, .rst_ni, .addr_i(bus_addr_i), .wr_i(bus_wr_i),
    .wdata_i(bus_wdata_i), .mask_o(mask), .en_o(chg_en)
  );

  always_comb begin
    status        = '0;
    status[B_TXA] = tx_rdy_a_i;
    status[B_RXA] = rx_rdy_a_i;
    status[B_BKA] = stk_q[0];
    status[B_CTR] = stk_q[1];
    status[B_TXB] = tx_rdy_b_i;
    status[B_RXB] = rx_rdy_b_i;
    status[B_BKB] = stk_q[2];
    status[B_COS] = |(chg_flag & chg_en);
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      unique case (bus_addr_i)
        REG_STATUS: bus_rdata_o = status;
        REG_MASK:   bus_rdata_o = mask;
        REG_AUX:    bus_rdata_o[NPIN-1:0] = chg_en;
        REG_CHG:    bus_rdata_o[NPIN-1:0] = chg_flag;
        default:    bus_rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(status & mask);
  end

  a_r2_irq_rise : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status & mask) != '0) |=> irq_o);
  a_r3_irq_masked : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status & mask) == '0) |=> !irq_o);
  a_r7_cos_gated : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_en == '0) |-> !status[B_COS]);
  a_r10_idle_bus : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |-> (bus_rdata_o == '0));
endmodule

// File: tb/sim_sio_irq_agg.sv
module sim_sio_irq_agg;
  logic       clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic       wr = 0, rd = 0;
  logic [7:0] wdata = 0, rdata;
  logic rxa = 0, txa = 0, bsa = 0, bca = 0, rxb = 0, txb = 0, bsb = 0, bcb = 0;
  logic cs = 0, cc = 0;
  logic [2:0] pin = 0;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  sio_irq_agg u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rx_rdy_a_i(rxa), .tx_rdy_a_i(txa), .brk_set_a_i(bsa), .brk_clr_a_i(bca),
    .rx_rdy_b_i(rxb), .tx_rdy_b_i(txb), .brk_set_b_i(bsb), .brk_clr_b_i(bcb),
    .ctr_set_i(cs), .ctr_clr_i(cc), .pin_i(pin), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {rxa, txa, rxb, txb, mask[7:0], exp_irq}
  localparam int NV = 6;
  localparam logic [12:0] VEC [NV] = '{
    {4'b1000, 8'h00, 1'b0},
    {4'b1000, 8'h02, 1'b1},
    {4'b0100, 8'h02, 1'b0},
    {4'b0100, 8'h01, 1'b1},
    {4'b0011, 8'hCC, 1'b0},
    {4'b0011, 8'h20, 1'b1}
  };

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    wait_n(3); rst_n = 1; wait_n(2);

    // R5 reset state, R3 irq low
    rd_reg(0, d); chk("R5 status", d, 8'h00);
    rd_reg(1, d); chk("R5 mask", d, 8'h00);
    rd_reg(2, d); chk("R5 aux", d, 8'h00);
    rd_reg(3, d); chk("R5 capture", d, 8'h00);
    chk("R3 irq after reset", {7'd0, irq}, 8'h00);

    // R1 R2 R3 R4 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0] es;
      {rxa, txa, rxb, txb} = VEC[i][12:9];
      wr_reg(1, VEC[i][8:1]);
      es = {2'b00, VEC[i][10], VEC[i][9], 2'b00, VEC[i][12], VEC[i][11]};
      wait_n(2);
      rd_reg(0, d); chk("R1 R4 status", d, es);
      chk("R2 R3 irq", {7'd0, irq}, {7'd0, VEC[i][0]});
    end
    {rxa, txa, rxb, txb} = 4'b0000;

    // R10 map
    wr_reg(2, 8'hFF); rd_reg(2, d); chk("R10 aux upper zero", d, 8'h07);
    wr_reg(0, 8'hFF); wr_reg(3, 8'hFF);
    rd_reg(0, d); chk("R10 status write ignored", d, 8'h00);
    rd_reg(3, d); chk("R10 capture write ignored", d, 8'h00);
    chk("R10 idle rdata", rdata, 8'h00);

    // R9 sticky bits
    wr_reg(1, 8'h4C);
    @(negedge clk); bsa = 1; cs = 1;
    @(negedge clk); bsa = 0; cs = 0;
    rd_reg(0, d); chk("R9 break A and counter set", d, 8'h0C);
    wait_n(1); chk("R2 irq from sticky", {7'd0, irq}, 8'h01);
    @(negedge clk); bsb = 1; bcb = 1;
    @(negedge clk); bsb = 0; bcb = 0;
    rd_reg(0, d); chk("R9 set wins", d, 8'h4C);
    @(negedge clk); bca = 1; cc = 1; bcb = 1;
    @(negedge clk); bca = 0; cc = 0; bcb = 0;
    rd_reg(0, d); chk("R9 clear", d, 8'h00);
    wait_n(1); chk("R2 irq falls", {7'd0, irq}, 8'h00);

    // R6 R7 R8 pin changes
    wr_reg(2, 8'h02); wr_reg(1, 8'h80);
    @(negedge clk); pin[0] = 1;
    wait_n(4);
    rd_reg(3, d); chk("R6 pin0 flag", d, 8'h01);
    rd_reg(3, d); chk("R8 read cleared", d, 8'h00);
    @(negedge clk); pin[0] = 0;
    wait_n(4);
    rd_reg(0, d); chk("R7 disabled pin leaves bit7", d, 8'h00);
    chk("R7 no irq", {7'd0, irq}, 8'h00);
    rd_reg(3, d);
    @(negedge clk); pin[1] = 1;
    wait_n(4);
    rd_reg(0, d); chk("R7 enabled pin sets bit7", d, 8'h80);
    chk("R7 irq", {7'd0, irq}, 8'h01);
    rd_reg(3, d); chk("R8 capture value", d, 8'h02);
    wait_n(1);
    rd_reg(0, d); chk("R8 bit7 falls", d, 8'h00);
    chk("R8 irq falls", {7'd0, irq}, 8'h00);

    // R8 set wins over read clear in same cycle
    @(negedge clk); pin[2] = 1;
    wait_n(1);
    rd_reg(3, d); chk("R8 pre-set read", d, 8'h00);
    rd_reg(3, d); chk("R8 set wins", d, 8'h04);

    // R6 level held through reset gives no flag
    @(negedge clk); rst_n = 0; pin = 3'b111;
    wait_n(2); rst_n = 1;
    wait_n(6);
    rd_reg(3, d); chk("R6 no flag from reset level", d, 8'h00);
    chk("R5 irq after reset", {7'd0, irq}, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule